// File: doc/BRIEF.md
# Memory Test Traffic Sequencer

This block is the control core of a memory test traffic generator. Software or a test harness programs a small bank of configuration registers through a one-cycle register-write port, then writes the start register (offset 0, any data) as the final access. The block then runs a test stage. The stage is a number of loops, and each loop is a block of write bursts followed by an equal-sized block of read bursts. Each transaction can be issued several times in a row before the sequencer moves on. Commands leave through a valid/ready command port that carries the direction, the burst length and the current base address.

Address and data values come from neighbouring generator blocks, and read checking is also done elsewhere. The sequencer drives those neighbours through two strobes. One asks for the next address when a transaction is finished. The other asks for the next data word on every accepted write. Between loops the sequencer updates the base address according to the configured address mode. A configuration in which the write and read counts differ is refused with an error flag.

Top module: `mem_traffic_seq`

## Requirements
- R1: After reset `cmd_valid`, `done` and `cfg_err` are all 0.
- R2: A write to register offset 0 (any data) launches a stage when the block is idle, and `cmd_valid` is high in the cycle after the clock edge that samples that write. A start write while `busy` is high is ignored and does not restart the stage.
- R3: If, at the start write, the write count (offset 2) differs from the read count (offset 3), `cfg_err` is 1 from the next cycle and no command is issued. A later start with equal counts clears `cfg_err`.
- R4: Each loop issues the write block (`cmd_write`=1) and then the read block (`cmd_write`=0). The loop count is at offset 1. A value of 0 in the loop, count or repeat registers counts as 1.
- R5: Each write is issued the number of times held at offset 4, and each read the number of times held at offset 5. The copies are consecutive accepted commands.
- R6: `cmd_len` equals the burst length register (offset 6, low 8 bits) on every command.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_write` and `cmd_base` stay unchanged.
- R8: `addr_next` is high exactly with the accepted last copy of each transaction. `data_next` is high exactly with each accepted write command.
- R9: At start, the base is loaded from offset 8. At each loop end, mode 1 (offset 7) adds the increment at offset 9. Modes 0 and 2 step a left-shifting LFSR: new = {base[30:0], parity(base & 0x80200003)}. Mode 3 leaves the base unchanged.
- R10: `done` is 1 from the cycle after the final read copy of the final loop is accepted. The next start write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cmd_ready | input | 1 | Command accepted by the memory side |
| cmd_valid | output | 1 | Command present |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_len | output | 8 | Burst length |
| cmd_base | output | 32 | Current base address |
| addr_next | output | 1 | Advance the address generator |
| data_next | output | 1 | Advance the data generator |
| busy | output | 1 | Stage in progress |
| done | output | 1 | Stage completed |
| cfg_err | output | 1 | Start refused: write and read counts differ |

## Verification
A start write sampled at edge k shows `cmd_valid` and `cfg_err` one cycle later. The command fields and both strobes are combinational in the cycle in which `cmd_ready` is driven, so the bench drives ready just after a falling edge and compares them before the next rising edge. The base address and `done` change at the accepting edge. The expected base is therefore checked on the first command of the following loop and again after the stage ends. Stall cycles are inserted with ready low, and the bench checks that the held command equals the expected one.

// File: rtl/mts_pkg.sv
// Shared definitions for the memory test traffic sequencer.
// Assumes a 4-bit register offset space.
package mts_pkg;
    typedef enum logic [3:0] {
        REG_START = 4'd0,
        REG_LOOPS = 4'd1,
        REG_WCNT  = 4'd2,
        REG_RCNT  = 4'd3,
        REG_WREP  = 4'd4,
        REG_RREP  = 4'd5,
        REG_BLEN  = 4'd6,
        REG_AMODE = 4'd7,
        REG_BASE  = 4'd8,
        REG_INCR  = 4'd9
    } reg_id_e;

    typedef enum logic [1:0] {
        AM_RAND = 2'd0,
        AM_SEQ  = 2'd1,
        AM_RSEQ = 2'd2,
        AM_HOLD = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2
    } phase_e;
endpackage

// File: rtl/mts_cfg_regs.sv
// Configuration register bank. It captures register writes and presents
// effective counts, in which a stored zero reads as one.
// Assumes AW <= DW. Writes to the start offset are decoded by the top.
module mts_cfg_regs
    import mts_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] eff_loops,
    output logic [CW-1:0] eff_wcnt,
    output logic [CW-1:0] eff_rcnt,
    output logic [CW-1:0] eff_wrep,
    output logic [CW-1:0] eff_rrep,
    output logic [LW-1:0] blen,
    output logic [1:0]    amode,
    output logic [AW-1:0] base_init,
    output logic [AW-1:0] incr
);
    logic [CW-1:0] loops_q, wcnt_q, rcnt_q, wrep_q, rrep_q;

    // Capture register writes by offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loops_q   <= '0;
            wcnt_q    <= '0;
            rcnt_q    <= '0;
            wrep_q    <= '0;
            rrep_q    <= '0;
            blen      <= '0;
            amode     <= AM_SEQ;
            base_init <= '0;
            incr      <= '0;
        end else if (we) begin
            case (reg_id_e'(addr))
                REG_LOOPS: loops_q   <= wdata[CW-1:0];
                REG_WCNT:  wcnt_q    <= wdata[CW-1:0];
                REG_RCNT:  rcnt_q    <= wdata[CW-1:0];
                REG_WREP:  wrep_q    <= wdata[CW-1:0];
                REG_RREP:  rrep_q    <= wdata[CW-1:0];
                REG_BLEN:  blen      <= wdata[LW-1:0];
                REG_AMODE: amode     <= wdata[1:0];
                REG_BASE:  base_init <= wdata[AW-1:0];
                REG_INCR:  incr      <= wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // Map a stored zero to one for every count.
    always_comb begin
        eff_loops = (loops_q == '0) ? CW'(1) : loops_q;
        eff_wcnt  = (wcnt_q  == '0) ? CW'(1) : wcnt_q;
        eff_rcnt  = (rcnt_q  == '0) ? CW'(1) : rcnt_q;
        eff_wrep  = (wrep_q  == '0) ? CW'(1) : wrep_q;
        eff_rrep  = (rrep_q  == '0) ? CW'(1) : rrep_q;
    end
endmodule

// File: rtl/mts_base_addr.sv
// Base address register. It loads the configured start value when a stage
// launches and updates it at each loop end according to the address mode.
// Assumes load and step are never high together.
module mts_base_addr
    import mts_pkg::*;
#(
    parameter int          AW   = 32,
    parameter logic [AW-1:0] TAPS = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] init,
    input  logic [AW-1:0] incr,
    output logic [AW-1:0] base
);
    // Load on launch, then add the increment, step the LFSR or hold at loop end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (load) begin
            base <= init;
        end else if (step) begin
            case (amode_e'(mode))
                AM_SEQ:           base <= base + incr;
                AM_RAND, AM_RSEQ: base <= {base[AW-2:0], ^(base & TAPS)};
                default:          base <= base;
            endcase
        end
    end

    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == AM_HOLD) |=> $stable(base)); // R9
endmodule

// File: rtl/mts_sequencer.sv
// Loop, block and repeat counters with the command-phase state machine.
// Assumes that go is only pulsed while the phase is idle, and that the
// count inputs are effective values (at least one).
module mts_sequencer
    import mts_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          start_any,
    input  logic [CW-1:0] loops,
    input  logic [CW-1:0] xacts,
    input  logic [CW-1:0] wrep,
    input  logic [CW-1:0] rrep,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic          addr_next,
    output logic          data_next,
    output logic          loop_end,
    output logic          busy,
    output logic          done
);
    phase_e        phase;
    logic [CW-1:0] loop_cnt, xact_cnt, rep_cnt, cur_rep;
    logic          accept, last_rep, last_xact, last_loop;

    // Decode the phase and the last-element conditions.
    always_comb begin
        cmd_valid = (phase != PH_IDLE);
        cmd_write = (phase == PH_WR);
        busy      = cmd_valid;
        cur_rep   = cmd_write ? wrep : rrep;
        accept    = cmd_valid && cmd_ready;
        last_rep  = (rep_cnt  == cur_rep - CW'(1));
        last_xact = (xact_cnt == xacts - CW'(1));
        last_loop = (loop_cnt == loops - CW'(1));
        addr_next = accept && last_rep;
        data_next = accept && cmd_write;
        loop_end  = accept && last_rep && last_xact && (phase == PH_RD);
    end

    // Advance the repeat, transaction and loop counters on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            loop_cnt <= '0;
            xact_cnt <= '0;
            rep_cnt  <= '0;
            done     <= 1'b0;
        end else begin
            if (start_any) done <= 1'b0;
            if (go) begin
                phase    <= PH_WR;
                loop_cnt <= '0;
                xact_cnt <= '0;
                rep_cnt  <= '0;
            end else if (accept) begin
                if (!last_rep) begin
                    rep_cnt <= rep_cnt + CW'(1);
                end else begin
                    rep_cnt <= '0;
                    if (!last_xact) begin
                        xact_cnt <= xact_cnt + CW'(1);
                    end else begin
                        xact_cnt <= '0;
                        if (phase == PH_WR) begin
                            phase <= PH_RD;
                        end else if (last_loop) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            loop_cnt <= loop_cnt + CW'(1);
                            phase    <= PH_WR;
                        end
                    end
                end
            end
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write))); // R7
    AST_REP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (rep_cnt < cur_rep)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R10
    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(go)); // R2
endmodule

// File: rtl/mem_traffic_seq.sv
// Memory test traffic sequencer top. It decodes the start write, checks
// that the write and read counts match, and ties together the register
// bank, the sequencer and the base address register.
// Assumes the start write is the last configuration access of a stage.
module mem_traffic_seq
    import mts_pkg::*;
#(
    parameter int            DW   = 32,
    parameter int            AW   = 32,
    parameter int            CW   = 16,
    parameter int            LW   = 8,
    parameter logic [AW-1:0] TAPS = 32'h8020_0003
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic [LW-1:0] cmd_len,
    output logic [AW-1:0] cmd_base,
    output logic          addr_next,
    output logic          data_next,
    output logic          busy,
    output logic          done,
    output logic          cfg_err
);
    logic [CW-1:0] eff_loops, eff_wcnt, eff_rcnt, eff_wrep, eff_rrep;
    logic [1:0]    amode;
    logic [AW-1:0] base_init, incr;
    logic          start_any, mismatch, go, loop_end;

    mts_cfg_regs #(.DW(DW), .AW(AW), .CW(CW), .LW(LW)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .eff_loops(eff_loops), .eff_wcnt(eff_wcnt), .eff_rcnt(eff_rcnt),
        .eff_wrep(eff_wrep), .eff_rrep(eff_rrep), .blen(cmd_len),
        .amode(amode), .base_init(base_init), .incr(incr)
    );

    // Decode a start write accepted while idle and screen the counts.
    always_comb begin
        start_any = cfg_we && (reg_id_e'(cfg_addr) == REG_START) && !busy;
        mismatch  = (eff_wcnt != eff_rcnt);
        go        = start_any && !mismatch;
    end

    // Record the outcome of the count check at each start.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_err <= 1'b0;
        else if (start_any) cfg_err <= mismatch;
    end

    mts_sequencer #(.CW(CW)) i_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .start_any(start_any),
        .loops(eff_loops), .xacts(eff_wcnt), .wrep(eff_wrep), .rrep(eff_rrep),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .addr_next(addr_next), .data_next(data_next), .loop_end(loop_end),
        .busy(busy), .done(done)
    );

    mts_base_addr #(.AW(AW), .TAPS(TAPS)) i_base (
        .clk(clk), .rst_n(rst_n), .load(go), .step(loop_end), .mode(amode),
        .init(base_init), .incr(incr), .base(cmd_base)
    );

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !cmd_valid); // R3
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> $stable(cmd_base)); // R7
endmodule

// File: tb/test_mem_traffic_seq.sv
`timescale 1ns/1ps
module test_mem_traffic_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid, cmd_write, addr_next, data_next, busy, done, cfg_err;
    logic [7:0]  cmd_len;
    logic [31:0] cmd_base;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mem_traffic_seq i_mem_traffic_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_len(cmd_len), .cmd_base(cmd_base),
        .addr_next(addr_next), .data_next(data_next), .busy(busy),
        .done(done), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [15:0] loops, wc, rc, wrep, rrep;
        logic [7:0]  blen;
        logic [1:0]  mode;
        logic [31:0] start, incr;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'd2, 16'd2, 16'd2, 16'd1, 16'd1, 8'd8,  2'd1, 32'h0000_0100, 32'h40, 1'b0},
        '{16'd0, 16'd3, 16'd3, 16'd2, 16'd3, 8'd4,  2'd1, 32'h0000_1000, 32'h10, 1'b1},
        '{16'd3, 16'd1, 16'd1, 16'd0, 16'd2, 8'd16, 2'd0, 32'h0000_ACE1, 32'h00, 1'b1},
        '{16'd2, 16'd2, 16'd2, 16'd1, 16'd1, 8'd2,  2'd3, 32'h0000_0055, 32'h04, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] eff(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], ^(s & 32'h8020_0003)};
    endfunction

    // Called just after a falling edge; returns just after the next one.
    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic run_stage(input vec_t v);
        logic [31:0] eb;
        logic [15:0] n, reps;
        bit wr;
        cmd_ready = 1'b0;
        cfg_write(4'd1, 32'(v.loops));
        cfg_write(4'd2, 32'(v.wc));
        cfg_write(4'd3, 32'(v.rc));
        cfg_write(4'd4, 32'(v.wrep));
        cfg_write(4'd5, 32'(v.rrep));
        cfg_write(4'd6, 32'(v.blen));
        cfg_write(4'd7, 32'(v.mode));
        cfg_write(4'd8, v.start);
        cfg_write(4'd9, v.incr);
        cfg_write(4'd0, 32'h0);
        chk(cmd_valid == 1'b1, "R2 valid after start", 64'(cmd_valid), 64'd1);
        chk(done == 1'b0, "R10 done cleared by start", 64'(done), 64'd0);
        chk(cfg_err == 1'b0, "R3 err clear on matched counts", 64'(cfg_err), 64'd0);
        eb = v.start;
        for (int l = 0; l < int'(eff(v.loops)); l++) begin
            for (int ph = 0; ph < 2; ph++) begin
                wr = (ph == 0);
                n = eff(v.wc);
                reps = wr ? eff(v.wrep) : eff(v.rrep);
                for (int x = 0; x < int'(n); x++) begin
                    for (int r = 0; r < int'(reps); r++) begin
                        if (v.stall && ((x + r + l) % 2 == 1)) begin
                            cmd_ready = 1'b0;
                            @(negedge clk); #1;
                            chk(cmd_valid == 1'b1, "R7 valid held", 64'(cmd_valid), 64'd1);
                            chk(cmd_write == wr, "R7 direction held", 64'(cmd_write), 64'(wr));
                            chk(cmd_base == eb, "R7 base held", 64'(cmd_base), 64'(eb));
                        end
                        cmd_ready = 1'b1; #0;
                        chk(cmd_valid == 1'b1, "R4 command present", 64'(cmd_valid), 64'd1);
                        chk(cmd_write == wr, "R4 R5 direction order", 64'(cmd_write), 64'(wr));
                        chk(cmd_len == v.blen, "R6 burst length", 64'(cmd_len), 64'(v.blen));
                        chk(cmd_base == eb, "R9 base address", 64'(cmd_base), 64'(eb));
                        chk(addr_next == (r == int'(reps) - 1), "R8 addr_next", 64'(addr_next), 64'(r == int'(reps) - 1));
                        chk(data_next == wr, "R8 data_next", 64'(data_next), 64'(wr));
                        @(negedge clk); #1;
                    end
                end
            end
            case (v.mode)
                2'd1:       eb = eb + v.incr;
                2'd0, 2'd2: eb = lfsr_next(eb);
                default:    eb = eb;
            endcase
        end
        cmd_ready = 1'b0; #0;
        chk(done == 1'b1, "R10 done after last read", 64'(done), 64'd1);
        chk(cmd_valid == 1'b0, "R4 no command after stage", 64'(cmd_valid), 64'd0);
        chk(cmd_base == eb, "R9 final base", 64'(cmd_base), 64'(eb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(cmd_valid == 1'b0, "R1 reset valid", 64'(cmd_valid), 64'd0);
        chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
        chk(cfg_err == 1'b0, "R1 reset err", 64'(cfg_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cmd_valid == 1'b0, "R1 idle after reset", 64'(cmd_valid), 64'd0);

        // R3: mismatched counts refuse the start
        cfg_write(4'd2, 32'd2);
        cfg_write(4'd3, 32'd3);
        cfg_write(4'd0, 32'h1234);
        chk(cfg_err == 1'b1, "R3 err on mismatch", 64'(cfg_err), 64'd1);
        chk(cmd_valid == 1'b0, "R3 no traffic on mismatch", 64'(cmd_valid), 64'd0);
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_valid == 1'b0, "R3 still no traffic", 64'(cmd_valid), 64'd0);
        cmd_ready = 1'b0;

        // Table of stage configurations
        foreach (VECS[i]) run_stage(VECS[i]);

        // R2: start while busy is ignored
        cfg_write(4'd1, 32'd1);
        cfg_write(4'd2, 32'd1);
        cfg_write(4'd3, 32'd1);
        cfg_write(4'd4, 32'd1);
        cfg_write(4'd5, 32'd1);
        cfg_write(4'd0, 32'd0);
        cmd_ready = 1'b1; #0;
        chk(cmd_write == 1'b1, "R4 write first", 64'(cmd_write), 64'd1);
        @(negedge clk); #1;
        cmd_ready = 1'b0;
        cfg_write(4'd0, 32'd0);
        chk(cmd_valid == 1'b1, "R2 busy start ignored valid", 64'(cmd_valid), 64'd1);
        chk(cmd_write == 1'b0, "R2 busy start no restart", 64'(cmd_write), 64'd0);
        cmd_ready = 1'b1;
        @(negedge clk); #1;
        cmd_ready = 1'b0;
        chk(done == 1'b1, "R10 done after short stage", 64'(done), 64'd1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule